// File: doc/BRIEF.md
# Interrupt Steering and Transfer Count Unit

This unit sits between a set of interrupt sources and two consumers: the processor's interrupt input and a data transfer engine. Every steerable source owns one bit in a bank of byte-wide enable registers that software reads and writes. A source whose bit is clear reaches the processor directly. A source whose bit is set becomes a transfer request, which is held until the engine reports that the move is complete. A small group of fixed sources cannot be steered and always goes straight to the processor.

Each steerable source has a 16-bit down-counter that software loads with the number of byte or word moves wanted. A loaded value of 0 stands for 65,536 moves. Every completed move lowers the counter by one. When the last move completes, the unit raises a processor interrupt on that source's own line, so the processor sees the vector of the source that started the transfers. The interrupt stays raised until the processor acknowledges it. The channel accepts no new requests until software reloads the counter.

Top module: `xfer_req_router`

## Requirements
- R1: After reset, every enable register and every counter reads 0. With all inputs low, `xfer_req` and `cpu_irq` are 0.
- R2: Writing enable register r (address r, with address bit SW at 0) stores `reg_wdata[7:0] & SRC_MASK[8r+7:8r]`, and reading it returns the stored byte in `reg_rdata[7:0]`. Positions cleared in `SRC_MASK` always read 0 and ignore writes.
- R3: A high `irq_in[s]` whose enable bit is 0 appears on `cpu_irq[s]` in the same cycle. One whose enable bit is 1 does not appear on `cpu_irq[s]`, and it sets `xfer_req[s]` from the next clock edge.
- R4: `fix_out` equals `fix_in` in the same cycle, whatever the enable registers hold.
- R5: `xfer_req[s]` stays set until a clock edge at which `ack_valid` is high with `ack_src == s`, and it is clear after that edge. If `irq_in[s]` is high at that same edge, the request stays set. An acknowledge for a source that has no pending request has no effect.
- R6: The counter of source s is read and written at address `2**SW + s`. Each acknowledge of a pending request lowers it by one, and a counter at 0 goes to 0xFFFF.
- R7: The acknowledge that takes a counter from 1 to 0 raises `cpu_irq[s]`. It stays high until a clock edge with `cpu_ack_valid` high and `cpu_ack_src == s`. A loaded 0 raises it only on the 65,536th acknowledge.
- R8: From that exhaustion until the counter of s is written again, `irq_in[s]` sets no request and reaches no processor line.
- R9: When a counter write and an acknowledge for the same source fall on one clock edge, the counter takes the written value. The request is still cleared, and no exhaustion interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SW+1 (7) | Register address: enable bank when the top bit is 0, counters when it is 1 |
| reg_wdata | input | CW (16) | Write data |
| reg_rdata | output | CW (16) | Read data for `reg_addr` |
| irq_in | input | NSRC (48) | Steerable interrupt sources |
| fix_in | input | NFIX (4) | Fixed, processor-only sources |
| xfer_req | output | NSRC (48) | Pending transfer requests |
| ack_valid | input | 1 | Transfer engine reports a completed move |
| ack_src | input | SW (6) | Source whose move completed |
| cpu_irq | output | NSRC (48) | Processor interrupt per source |
| fix_out | output | NFIX (4) | Fixed sources to the processor |
| cpu_ack_valid | input | 1 | Processor acknowledges an exhaustion interrupt |
| cpu_ack_src | input | SW (6) | Source being acknowledged |

## Verification
Two kinds of event can fall on the same clock edge. The first is a software counter write together with a move completion for the same channel. The second is a new interrupt pulse together with the acknowledge that retires the previous request. The bench provokes both by raising the write or the pulse and the acknowledge in one cycle. For the first, it judges from the counter read-back, `xfer_req` and `cpu_irq` that the written value wins and that no exhaustion is signalled. For the second, it judges from `xfer_req` that the request survives. The 65,536-move case is run with a pulse and an acknowledge on every cycle, which also tests this overlap on a long stream.

// File: rtl/xfer_req_router.sv
module xfer_req_router #(
  parameter int NREG = 6,
  parameter int NFIX = 4,
  parameter int CW = 16,
  parameter logic [NREG*8-1:0] SRC_MASK = 48'h0F3C_77E7_33C3,
  localparam int NSRC = NREG * 8,
  localparam int SW = $clog2(NSRC),
  localparam int AW = SW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [CW-1:0]   reg_wdata,
  output logic [CW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NFIX-1:0] fix_in,
  output logic [NSRC-1:0] xfer_req,
  input  logic            ack_valid,
  input  logic [SW-1:0]   ack_src,
  output logic [NSRC-1:0] cpu_irq,
  output logic [NFIX-1:0] fix_out,
  input  logic            cpu_ack_valid,
  input  logic [SW-1:0]   cpu_ack_src
);

  logic [NSRC-1:0] en, pend, fin, lock;
  logic [CW-1:0]   cnt [NSRC];

  wire [SW-1:0]   aidx    = reg_addr[SW-1:0];
  wire            cnt_sel = reg_addr[SW];
  wire [NSRC-1:0] ack_hit = ack_valid ? ((NSRC'(1) << ack_src) & pend) : '0;
  wire [NSRC-1:0] cack    = cpu_ack_valid ? (NSRC'(1) << cpu_ack_src) : '0;
  wire [NSRC-1:0] cwr     = (reg_wr && cnt_sel) ? (NSRC'(1) << aidx) : '0;

  logic [NSRC-1:0] last;
  always_comb
    for (int s = 0; s < NSRC; s++)
      last[s] = ack_hit[s] && !cwr[s] && (cnt[s] == CW'(1));

  assign xfer_req = pend;
  assign cpu_irq  = (irq_in & ~en & ~lock) | fin;
  assign fix_out  = fix_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= '0;
    else if (reg_wr && !cnt_sel)
      for (int r = 0; r < NREG; r++)
        if (int'(aidx) == r) en[r*8 +: 8] <= reg_wdata[7:0] & SRC_MASK[r*8 +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0;
      fin  <= '0;
      lock <= '0;
      for (int s = 0; s < NSRC; s++) cnt[s] <= '0;
    end else begin
      pend <= (irq_in & en & ~lock & ~last) | (pend & ~ack_hit);
      fin  <= last | (fin & ~cack);
      lock <= last | (lock & ~cwr);
      for (int s = 0; s < NSRC; s++)
        if (cwr[s]) cnt[s] <= reg_wdata;
        else if (ack_hit[s]) cnt[s] <= cnt[s] - CW'(1);
    end

  always_comb begin
    reg_rdata = '0;
    if (cnt_sel) begin
      if (int'(aidx) < NSRC) reg_rdata = cnt[aidx];
    end else if (int'(aidx) < NREG) begin
      reg_rdata = CW'(en[int'(aidx)*8 +: 8]);
    end
  end

endmodule

module xfer_req_router_chk #(
  parameter int NSRC = 48,
  parameter int SW = 6,
  parameter logic [NSRC-1:0] MASK = '1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_in,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] fin,
  input logic [NSRC-1:0] lock,
  input logic            ack_valid,
  input logic [SW-1:0]   ack_src,
  input logic            cpu_ack_valid,
  input logic [SW-1:0]   cpu_ack_src
);

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n) (en & ~MASK) == '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[s]) |-> $past(irq_in[s] && en[s]));
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[s] && !(ack_valid && ack_src == SW'(s))) |=> pend[s]);
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[s] && ack_valid && ack_src == SW'(s) && !irq_in[s]) |=> !pend[s]);
    p_fin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin[s] && !(cpu_ack_valid && cpu_ack_src == SW'(s))) |=> fin[s]);
    p_lock_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock[s] |=> !pend[s]);
  end

endmodule

bind xfer_req_router xfer_req_router_chk #(.NSRC(NSRC), .SW(SW), .MASK(SRC_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en(en), .pend(pend), .fin(fin),
  .lock(lock), .ack_valid(ack_valid), .ack_src(ack_src),
  .cpu_ack_valid(cpu_ack_valid), .cpu_ack_src(cpu_ack_src)
);

// File: tb/sim_xfer_req_router.sv
`timescale 1ns/1ps
module sim_xfer_req_router;
  localparam int NREG = 2, NFIX = 3, CW = 16, NSRC = 16, SW = 4, AW = 5;
  localparam logic [15:0] MASK = 16'h5AF3;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic [NSRC-1:0] irq_in = '0, xfer_req, cpu_irq;
  logic [NFIX-1:0] fix_in = '0, fix_out;
  logic ack_valid = 0, cpu_ack_valid = 0;
  logic [SW-1:0] ack_src = '0, cpu_ack_src = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xfer_req_router #(.NREG(NREG), .NFIX(NFIX), .CW(CW), .SRC_MASK(MASK)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick;
    reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [CW-1:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse_ack(int s);
    irq_in = NSRC'(1) << s; tick; irq_in = '0;
    ack_valid = 1; ack_src = SW'(s); tick; ack_valid = 0;
  endtask

  initial begin
    #(250000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    logic [NSRC-1:0] en;
    int s;
    #5 rst_n = 1; tick;

    // R1 reset state
    for (int r = 0; r < NREG; r++) begin rd(AW'(r), v); chk("R1 enable", v, 0); end
    for (int i = 0; i < NSRC; i++) begin rd(AW'(16 + i), v); chk("R1 counter", v, 0); end
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 cpu_irq", cpu_irq, 0);

    // R2 exhaustive write/read of enable bank
    for (int r = 0; r < NREG; r++)
      for (int d = 0; d < 256; d++) begin
        wr(AW'(r), CW'(d));
        rd(AW'(r), v);
        chk("R2 enable rw", v, d & MASK[r*8 +: 8]);
      end

    // R3 routing sweep with every assigned bit enabled
    wr(0, 16'hFF); wr(1, 16'hFF);
    en = MASK;
    for (int i = 0; i < NSRC; i++) begin
      irq_in = NSRC'(1) << i; #0.5;
      chk("R3 cpu path", cpu_irq, en[i] ? 0 : (NSRC'(1) << i));
      tick; irq_in = '0;
      chk("R3 xfer path", xfer_req, en[i] ? (NSRC'(1) << i) : 0);
      if (en[i]) begin ack_valid = 1; ack_src = SW'(i); tick; ack_valid = 0; end
    end

    // R4 fixed sources
    for (int f = 0; f < 8; f++) begin
      fix_in = NFIX'(f); #0.5; chk("R4 fixed pass", fix_out, f);
    end
    fix_in = '0;

    // R5 hold, clear, overlap, stray acknowledge
    wr(16 + 0, 16'd100);
    irq_in = 1; tick; irq_in = 0;
    tick; tick; tick;
    chk("R5 held", xfer_req, 1);
    ack_valid = 1; ack_src = 0; irq_in = 1; tick; irq_in = 0; ack_valid = 0;
    chk("R5 overlap kept", xfer_req, 1);
    ack_valid = 1; ack_src = 0; tick; ack_valid = 0;
    chk("R5 cleared", xfer_req, 0);
    ack_valid = 1; ack_src = 0; tick; ack_valid = 0;
    rd(16 + 0, v); chk("R5 stray ack ignored", v, 98);

    // R6/R7/R8 countdown, exhaustion, lockout, reload
    foreach (en[i]) ;
    for (int k = 0; k < 4; k++) begin
      s = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? 9 : 14;
      wr(AW'(16 + s), CW'(k + 2));
      for (int n = 1; n <= k + 2; n++) begin
        chk("R7 no early irq", cpu_irq, 0);
        pulse_ack(s);
        rd(AW'(16 + s), v); chk("R6 decrement", v, k + 2 - n);
      end
      chk("R7 exhaust irq", cpu_irq, NSRC'(1) << s);
      tick; tick;
      chk("R7 irq held", cpu_irq, NSRC'(1) << s);
      cpu_ack_valid = 1; cpu_ack_src = SW'(s); tick; cpu_ack_valid = 0;
      chk("R7 irq cleared", cpu_irq, 0);
      irq_in = NSRC'(1) << s; #0.5;
      chk("R8 locked cpu", cpu_irq, 0);
      tick; irq_in = '0;
      chk("R8 locked req", xfer_req, 0);
      wr(AW'(16 + s), 16'd3);
      irq_in = NSRC'(1) << s; tick; irq_in = '0;
      chk("R8 reload accepts", xfer_req, NSRC'(1) << s);
      ack_valid = 1; ack_src = SW'(s); tick; ack_valid = 0;
    end

    // R9 write and acknowledge in one cycle
    wr(16 + 4, 16'd1);
    irq_in = 16'h0010; tick; irq_in = '0;
    reg_wr = 1; reg_addr = 16 + 4; reg_wdata = 16'd7;
    ack_valid = 1; ack_src = 4; tick; reg_wr = 0; ack_valid = 0;
    rd(16 + 4, v); chk("R9 write wins", v, 7);
    chk("R9 req cleared", xfer_req, 0);
    chk("R9 no exhaust", cpu_irq, 0);

    // R7 loaded zero means 65536 moves
    wr(16 + 5, 16'd0);
    irq_in = 16'h0020; tick;
    ack_valid = 1; ack_src = 5;
    for (int n = 0; n < 65535; n++) tick;
    irq_in = '0; #0.5;
    rd(16 + 5, v); chk("R7 65535 done", v, 1);
    chk("R7 not yet", cpu_irq, 0);
    tick; ack_valid = 0;
    chk("R7 65536 exhaust", cpu_irq, 16'h0020);
    chk("R7 65536 req", xfer_req, 0);
    rd(16 + 5, v); chk("R7 65536 count", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule